// File: doc/BRIEF.md
# Bridge Control Register and Interrupt Unit

This block holds the control and status registers of a bus bridge. A guarded system word drives the reset line of the downstream bus. That word can be changed only after a 16-bit key opens it. An eight-source interrupt status register has a mask and a single registered interrupt request. A four-flag error register records faults on the downstream bus.

Software reaches every register through one simple write/read port: a word address, a write strobe and write data. The read data is combinational from the address. Hardware raises status and error bits through single-cycle event inputs.

The guard on the system word protects the bus reset from stray writes. The interrupt status clears in bulk when zero is written to it. Error flags clear individually, so software can write back exactly what it read.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After reset the system word reads 0x4000: it is guarded (bit 14 = 1) and the bus reset is active (`pci_rst_n` = 0, bit 15 = 0). The interrupt status, mask and error registers read zero and `irq_o` is 0.
- R2: While bit 14 of the system word is 1, a write to address 0 with any value other than 0xA05F leaves the whole system word and `pci_rst_n` unchanged.
- R3: A write of 0xA05F to address 0 clears bit 14 of the system word and leaves its other bits unchanged.
- R4: While bit 14 is 0, a write to address 0 stores the full value. Bit 15 of the system word drives `pci_rst_n` (1 releases the bus). Writing bit 14 as 1 guards the word again.
- R5: Interrupt status (address 1, bits 7:0) is sticky. Bit n is set by a pulse on `irq_evt[n]`. The bit assignments are: 7 mailbox, 6 read abort, 5 write abort, 4 pin interrupt, 3 parity error, 2 inbound queue post, 1 DMA channel 1, 0 DMA channel 0.
- R6: The mask (address 2, bits 7:0, same layout as R5) is read/write. Only status bits whose mask bit is 1 can raise `irq_o`.
- R7: Writing 0x0000 to address 1 clears all interrupt status bits. Writing any nonzero value to address 1 has no effect.
- R8: `irq_o` is registered. It equals the OR of (status AND mask) as held one clock earlier, so it falls one clock after the status is cleared.
- R9: An event in the same cycle as a clearing write wins, for both interrupt status and error flags, and its bit stays set.
- R10: Error flags (address 3) are bit 15 parity error (`err_evt[3]`), bit 14 system error (`err_evt[2]`), bit 13 master abort (`err_evt[1]`) and bit 12 target abort (`err_evt[0]`). Each flag is sticky when set.
- R11: Writing address 3 clears each error flag whose write data bit is 1 and leaves the others unchanged.
- R12: Register addresses are 0 system, 1 interrupt status, 2 mask, 3 error. Unused read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq_evt | input | 8 | Interrupt source event pulses |
| err_evt | input | 4 | Bus error event pulses |
| pci_rst_n | output | 1 | Downstream bus reset, active low |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The guard is tried with a value that would change the reset line, with an all-zero value and with the key. This separates a guard that drops every write from one that also drops the key, and from one that wrongly stores the key as data. The interrupt path is driven with two sources under a mask that passes only one of them, then with a mask that passes none. This tells masking apart from plain OR-ing. A sample taken in the same cycle as a mask or clear write separates the registered request from a combinational one. Clearing writes are issued alone, with nonzero data, and together with new events. This shows bulk clear, ignored writes and the priority of events. The error flags are cleared one at a time to show per-bit clearing.

// File: rtl/bctl_pkg.sv
package bctl_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int N_IRQ     = 8;
    localparam int N_ERR     = 4;
    localparam int ERR_LSB   = 12;
    localparam int RSTOUT_B  = 15;
    localparam int GUARD_B   = 14;

    localparam logic [DATA_W-1:0] OPEN_KEY  = 16'hA05F;
    localparam logic [DATA_W-1:0] SYS_INIT  = 16'h4000;

    typedef enum logic [ADDR_W-1:0] {
        RA_SYS   = 2'd0,
        RA_ISTAT = 2'd1,
        RA_IMASK = 2'd2,
        RA_ERR   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              sys;
        logic              istat;
        logic              imask;
        logic              err;
    } wr_sel_t;

    function automatic wr_sel_t decode_wr(input logic we, input logic [ADDR_W-1:0] a);
        wr_sel_t s;
        s.sys   = we && (a == RA_SYS);
        s.istat = we && (a == RA_ISTAT);
        s.imask = we && (a == RA_IMASK);
        s.err   = we && (a == RA_ERR);
        return s;
    endfunction
endpackage

// File: rtl/bctl_sysreg.sv
module bctl_sysreg
    import bctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sys_q
);
    logic key_hit;
    assign key_hit = (wdata == OPEN_KEY[W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_q <= SYS_INIT[W-1:0];
        end else if (wr) begin
            if (key_hit) begin
                sys_q[GUARD_B] <= 1'b0;
            end else if (!sys_q[GUARD_B]) begin
                sys_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/bctl_irq.sv
module bctl_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_all,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_d,
    output logic [N-1:0] stat_q,
    output logic [N-1:0] mask_q,
    output logic         irq_q
);
    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[g] <= 1'b0;
            end else if (evt[g]) begin
                stat_q[g] <= 1'b1;
            end else if (clr_all) begin
                stat_q[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (mask_wr) begin
                mask_q <= mask_d;
            end
            irq_q <= |(stat_q & mask_q);
        end
    end
endmodule

// File: rtl/bctl_err.sv
module bctl_err #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         wr,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] flag_q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[g] <= 1'b0;
            end else if (evt[g]) begin
                flag_q[g] <= 1'b1;
            end else if (wr && w1c[g]) begin
                flag_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
    import bctl_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int NIRQ = N_IRQ,
    parameter int NERR = N_ERR
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NIRQ-1:0] irq_evt,
    input  logic [NERR-1:0] err_evt,
    output logic            pci_rst_n,
    output logic            irq_o
);
    localparam int ERR_HI = ERR_LSB + NERR - 1;

    wr_sel_t         sel;
    logic [DW-1:0]   sys_word;
    logic [NIRQ-1:0] istat_word;
    logic [NIRQ-1:0] imask_word;
    logic [NERR-1:0] err_word;
    logic            zero_wr;

    assign sel     = decode_wr(wr_en, addr);
    assign zero_wr = sel.istat && (wdata == '0);

    bctl_sysreg #(.W(DW)) u_sys (
        .clk   (clk),
        .rst   (rst),
        .wr    (sel.sys),
        .wdata (wdata),
        .sys_q (sys_word)
    );

    bctl_irq #(.N(NIRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (irq_evt),
        .clr_all (zero_wr),
        .mask_wr (sel.imask),
        .mask_d  (wdata[NIRQ-1:0]),
        .stat_q  (istat_word),
        .mask_q  (imask_word),
        .irq_q   (irq_o)
    );

    bctl_err #(.N(NERR)) u_err (
        .clk    (clk),
        .rst    (rst),
        .evt    (err_evt),
        .wr     (sel.err),
        .w1c    (wdata[ERR_HI:ERR_LSB]),
        .flag_q (err_word)
    );

    assign pci_rst_n = sys_word[RSTOUT_B];

    always_comb begin
        rdata = '0;
        case (addr)
            RA_SYS:   rdata = sys_word;
            RA_ISTAT: rdata[NIRQ-1:0] = istat_word;
            RA_IMASK: rdata[NIRQ-1:0] = imask_word;
            RA_ERR:   rdata[ERR_HI:ERR_LSB] = err_word;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/bctl_regs_chk.sv
module bctl_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [15:0] wdata,
    input logic [7:0]  irq_evt,
    input logic [3:0]  err_evt,
    input logic [15:0] sys_word,
    input logic [7:0]  istat_word,
    input logic [7:0]  imask_word,
    input logic [3:0]  err_word,
    input logic        irq_o
);
    // R2: guarded word ignores non-key writes
    p_guard_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (sys_word[14] && wr_en && addr == 2'd0 && wdata != 16'hA05F) |=> $stable(sys_word));

    // R3: key opens the guard
    p_key_open_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0 && wdata == 16'hA05F) |=> !sys_word[14]);

    // R7: zero write leaves only same-cycle events
    p_zero_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1 && wdata == 16'h0000) |=> (istat_word == $past(irq_evt)));

    // R8: request follows masked status one clock later
    p_irq_lag_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(istat_word & imask_word))));

    // R9: interrupt events always land
    p_evt_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (|irq_evt) |=> ((istat_word & $past(irq_evt)) == $past(irq_evt)));

    // R11: written ones clear flags that see no event
    p_err_w1c_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3) |=> ((err_word & $past(wdata[15:12]) & ~$past(err_evt)) == 4'd0));

    // R10: error events always land
    p_err_set_r10: assert property (@(posedge clk) disable iff (rst)
        (|err_evt) |=> ((err_word & $past(err_evt)) == $past(err_evt)));
endmodule

bind bridge_ctl_regs bctl_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .irq_evt    (irq_evt),
    .err_evt    (err_evt),
    .sys_word   (sys_word),
    .istat_word (istat_word),
    .imask_word (imask_word),
    .err_word   (err_word),
    .irq_o      (irq_o)
);

// File: tb/sim_bridge_ctl_regs.sv
module sim_bridge_ctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [7:0]  irq_evt = 8'h0;
    logic [3:0]  err_evt = 4'h0;
    logic        pci_rst_n;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef enum int {K_REG, K_IRQ, K_RSTN} kind_e;
    typedef struct {
        kind_e       kind;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    bridge_ctl_regs u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_evt(irq_evt), .err_evt(err_evt),
        .pci_rst_n(pci_rst_n), .irq_o(irq_o)
    );

    // monitor: compare at falling edges
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_REG:   act = rdata;
                K_IRQ:   act = {15'd0, irq_o};
                default: act = {15'd0, pci_rst_n};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_now(input kind_e k, input logic [1:0] a,
                              input logic [15:0] e, input string tag);
        item_t it;
        addr = a;
        it.kind = k; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_next(input kind_e k, input logic [1:0] a,
                               input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        expect_now(k, a, e, tag);
    endtask

    task automatic wr_evt(input logic [1:0] a, input logic [15:0] d,
                          input logic [7:0] ie, input logic [3:0] ee);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d; irq_evt = ie; err_evt = ee;
        @(posedge clk); #1;
        wr_en = 1'b0; irq_evt = 8'h0; err_evt = 4'h0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_evt(a, d, 8'h0, 4'h0);
    endtask

    task automatic pulse(input logic [7:0] ie, input logic [3:0] ee);
        @(posedge clk); #1;
        irq_evt = ie; err_evt = ee;
        @(posedge clk); #1;
        irq_evt = 8'h0; err_evt = 4'h0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state (R12 addresses)
        expect_now(K_REG, 2'd0, 16'h4000, "R1 sys reset");
        expect_now(K_RSTN, 2'd0, 16'h0, "R1 rst_n reset");
        expect_now(K_REG, 2'd1, 16'h0, "R1 istat reset");
        expect_now(K_REG, 2'd2, 16'h0, "R1 mask reset");
        expect_now(K_REG, 2'd3, 16'h0, "R1 err reset");
        expect_now(K_IRQ, 2'd0, 16'h0, "R1 irq reset");

        // R2 guarded writes ignored
        wr(2'd0, 16'h8000);
        expect_next(K_REG, 2'd0, 16'h4000, "R2 guarded write");
        expect_now(K_RSTN, 2'd0, 16'h0, "R2 rst_n held");
        // R3 key
        wr(2'd0, 16'hA05F);
        expect_next(K_REG, 2'd0, 16'h0000, "R3 key opens");
        // R4 store and release reset
        wr(2'd0, 16'h8000);
        expect_next(K_REG, 2'd0, 16'h8000, "R4 store");
        expect_now(K_RSTN, 2'd0, 16'h1, "R4 rst_n release");
        wr(2'd0, 16'hC000);
        expect_next(K_REG, 2'd0, 16'hC000, "R4 reguard");
        wr(2'd0, 16'h0000);
        expect_next(K_REG, 2'd0, 16'hC000, "R2 zero write guarded");
        expect_now(K_RSTN, 2'd0, 16'h1, "R2 rst_n unchanged");
        wr(2'd0, 16'hA05F);
        expect_next(K_REG, 2'd0, 16'h8000, "R3 key keeps other bits");

        // R5 status set by events
        pulse(8'h24, 4'h0);
        expect_next(K_REG, 2'd1, 16'h0024, "R5 status set");
        expect_now(K_IRQ, 2'd0, 16'h0, "R6 masked off");
        // R6/R8 mask
        wr(2'd2, 16'h0020);
        expect_now(K_IRQ, 2'd0, 16'h0, "R8 irq lags mask");
        expect_next(K_IRQ, 2'd0, 16'h1, "R6 irq on");
        expect_now(K_REG, 2'd2, 16'h0020, "R6 mask readback");
        // R7 nonzero ignored
        wr(2'd1, 16'h0055);
        expect_now(K_REG, 2'd1, 16'h0024, "R7 nonzero ignored");
        // R7 zero clears, R8 timing
        wr(2'd1, 16'h0000);
        expect_now(K_IRQ, 2'd0, 16'h1, "R8 irq one clock late");
        expect_now(K_REG, 2'd1, 16'h0000, "R7 cleared");
        expect_now(K_IRQ, 2'd0, 16'h0, "R8 irq falls");
        // R9 event beats clear
        pulse(8'h03, 4'h0);
        wr_evt(2'd1, 16'h0000, 8'h80, 4'h0);
        expect_now(K_REG, 2'd1, 16'h0080, "R9 event wins clear");
        expect_next(K_IRQ, 2'd0, 16'h0, "R6 unmasked source blocked");
        wr(2'd2, 16'h0080);
        expect_next(K_IRQ, 2'd0, 16'h1, "R6 mailbox source");
        wr(2'd2, 16'h0001);
        expect_next(K_IRQ, 2'd0, 16'h0, "R6 mask moved away");

        // R10 error flags
        pulse(8'h00, 4'b1010);
        expect_next(K_REG, 2'd3, 16'hA000, "R10 error positions");
        wr(2'd3, 16'h2000);
        expect_now(K_REG, 2'd3, 16'h8000, "R11 clear one flag");
        wr(2'd3, 16'h0000);
        expect_now(K_REG, 2'd3, 16'h8000, "R11 zero write no clear");
        wr_evt(2'd3, 16'h8000, 8'h00, 4'b1000);
        expect_now(K_REG, 2'd3, 16'h8000, "R9 error event wins");
        wr(2'd3, 16'h8000);
        expect_now(K_REG, 2'd3, 16'h0000, "R11 cleared");
        expect_now(K_REG, 2'd2, 16'h0001, "R12 mask upper bits zero");

        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule